// File: doc/BRIEF.md
# PCI-X Read Request Generator

This block sits between an upstream read-request source and a PCI-X bus master. Each upstream request carries a start address, a length counted in 32-bit DWords, and two attribute bits: no-snoop and relaxed-ordering. The block turns each request into one or two bus read requests. Each bus request carries an address, a byte count, a tag and the two attribute bits.

Three rules shape the output. A bus request never runs past a 4 KB address boundary. At most two requests are outstanding, so the tag is always 0 or 1. The two attribute bits pass through untouched. A tag returns to the pool when the completion side reports the final completion for that tag. While both tags are in use, the output waits.

Both request ports use a valid/ready handshake. Addresses are expected to be DWord aligned. The length parameter must keep the largest request at or below one page (LEN_W + 2 <= PAGE_W).

Top module: `pcix_rdreq_gen`

## Requirements
- R1: The byte count of a request equals its DWord length times four. A length field of zero means 2^LEN_W DWords, which is 4096 bytes by default.
- R2: No bus request crosses a 4 KB boundary. A request that would cross one is issued as two bus requests. The first runs up to the boundary. The second starts exactly at the boundary and carries the remaining bytes.
- R3: Only tags 0 and 1 are issued, and only while that tag is free. While both tags are held, bus_valid stays low.
- R4: When a bus request is first offered, it takes the lowest-numbered free tag.
- R5: A tag is freed only by cpl_valid with cpl_final = 1 for that tag. A completion with cpl_final = 0 leaves the tag held.
- R6: bus_ns equals the no-snoop bit of the request that produced the bus request, on every piece.
- R7: bus_ro equals the relaxed-ordering bit of the originating request. It is never raised otherwise.
- R8: Bus requests leave in input order. Both pieces of a split request go out back to back. req_ready stays low until the last piece of the current request has been taken.
- R9: While bus_valid is high and bus_ready is low, bus_valid stays high and every bus field, including the tag, holds its value.
- R10: After reset, bus_valid is 0, req_ready is 1 and both tags are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Request start byte address, DWord aligned |
| req_len | input | LEN_W | Length in DWords, 0 = 2^LEN_W |
| req_ns | input | 1 | No-snoop attribute |
| req_ro | input | 1 | Relaxed-ordering attribute |
| bus_valid | output | 1 | Bus read request valid |
| bus_ready | input | 1 | Bus master takes the request |
| bus_addr | output | ADDR_W | Bus request start address |
| bus_bcount | output | LEN_W+3 | Bus request byte count |
| bus_tag | output | 1 | Tag, 0 or 1 |
| bus_ns | output | 1 | Forwarded no-snoop |
| bus_ro | output | 1 | Forwarded relaxed-ordering |
| cpl_valid | input | 1 | Completion report valid |
| cpl_tag | input | 1 | Tag of the reported completion |
| cpl_final | input | 1 | Completion is the last for its tag |

## Verification
A request accepted on one rising edge shows its first bus piece right after that edge, when a tag is free. The second piece appears right after the edge that takes the first. A final completion makes its tag available right after the edge that captures it. The bench drives inputs on falling edges and samples outputs on the falling edge after the edge that produced them. When it expects a stall, it checks bus_valid on several falling edges in a row.

// File: rtl/pcix_rdreq_pkg.sv
package pcix_rdreq_pkg;
  localparam int TAG_COUNT = 2;
  typedef logic [0:0] tag_t;
  typedef struct packed {
    logic ns;
    logic ro;
  } attr_t;
endpackage

// File: rtl/rdreq_splitter.sv
module rdreq_splitter
  import pcix_rdreq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 10,
  parameter int PAGE_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic [LEN_W-1:0]     in_len,
  input  attr_t                in_attr,
  output logic                 piece_valid,
  input  logic                 piece_take,
  output logic [ADDR_W-1:0]    piece_addr,
  output logic [LEN_W+2:0]     piece_bcount,
  output attr_t                piece_attr,
  output logic                 piece_last
);
  localparam int BC_W = LEN_W + 3;
  localparam int PW1  = PAGE_W + 1;

  // DWord length to bytes; a zero length field stands for the largest size
  function automatic logic [BC_W-1:0] dw_to_bytes(input logic [LEN_W-1:0] len);
    if (len == '0) return BC_W'(1) << (LEN_W + 2);
    return {1'b0, len, 2'b00};
  endfunction

  // bytes left before the next page boundary
  function automatic logic [BC_W-1:0] page_room(input logic [ADDR_W-1:0] a);
    logic [PW1-1:0] r;
    r = (PW1'(1) << PAGE_W) - {1'b0, a[PAGE_W-1:0]};
    return BC_W'(r);
  endfunction

  function automatic logic [BC_W-1:0] min_bytes(input logic [BC_W-1:0] x,
                                                input logic [BC_W-1:0] y);
    return (x < y) ? x : y;
  endfunction

  logic              busy;
  logic [ADDR_W-1:0] cur_addr;
  logic [BC_W-1:0]   rem_bytes;
  attr_t             cur_attr;
  logic [BC_W-1:0]   this_piece;
  logic              accept;

  assign this_piece   = min_bytes(rem_bytes, page_room(cur_addr));
  assign accept       = in_valid && in_ready;
  assign in_ready     = !busy;
  assign piece_valid  = busy;
  assign piece_addr   = cur_addr;
  assign piece_bcount = this_piece;
  assign piece_attr   = cur_attr;
  assign piece_last   = (rem_bytes == this_piece);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cur_addr  <= '0;
      rem_bytes <= '0;
      cur_attr  <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      cur_addr  <= in_addr;
      rem_bytes <= dw_to_bytes(in_len);
      cur_attr  <= in_attr;
    end else if (piece_valid && piece_take) begin
      if (piece_last) busy <= 1'b0;
      cur_addr  <= cur_addr + ADDR_W'(this_piece);
      rem_bytes <= rem_bytes - this_piece;
    end
  end

  // R2: a piece never extends past the end of its page
  assert_piece_in_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    piece_valid |-> ((PAGE_W+2)'(piece_addr[PAGE_W-1:0]) + (PAGE_W+2)'(piece_bcount))
                    <= ((PAGE_W+2)'(1) << PAGE_W));

  // R1: every piece carries some bytes
  assert_piece_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    piece_valid |-> piece_bcount != '0);

  // R2/R8: the follow-on piece comes next and starts on a boundary
  assert_second_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (piece_valid && piece_take && !piece_last) |=>
      (piece_valid && piece_addr[PAGE_W-1:0] == '0));
endmodule

// File: rtl/rdreq_tag_pool.sv
module rdreq_tag_pool
  import pcix_rdreq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic take,
  input  logic rel_valid,
  input  tag_t rel_tag,
  input  logic rel_final,
  output logic avail,
  output tag_t tag
);
  logic [TAG_COUNT-1:0] free_q;
  logic                 held_valid;
  tag_t                 held_tag;
  tag_t                 lowest_free;
  logic                 issue_fire;
  logic                 release_fire;

  assign lowest_free  = free_q[0] ? tag_t'(0) : tag_t'(1);
  assign avail        = held_valid || (free_q != '0);
  assign tag          = held_valid ? held_tag : lowest_free;
  assign issue_fire   = want && avail && take;
  assign release_fire = rel_valid && rel_final;

  for (genvar g = 0; g < TAG_COUNT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        free_q[g] <= 1'b1;
      else if (issue_fire && tag == tag_t'(g))
        free_q[g] <= 1'b0;
      else if (release_fire && rel_tag == tag_t'(g))
        free_q[g] <= 1'b1;
    end
  end

  // keep the offered tag fixed while the offer waits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_tag   <= '0;
    end else begin
      held_valid <= want && avail && !take;
      held_tag   <= tag;
    end
  end

  // R3: an issued tag was free at issue time
  assert_issue_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> free_q[tag]);

  // R4: a fresh offer picks tag 0 whenever tag 0 is free
  assert_lowest_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && !held_valid && free_q[0]) |-> tag == tag_t'(0));

  // R5: a non-final completion releases nothing
  assert_nonfinal_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !rel_final && !issue_fire) |=> $stable(free_q));
endmodule

// File: rtl/pcix_rdreq_gen.sv
module pcix_rdreq_gen
  import pcix_rdreq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 10,
  parameter int PAGE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_ns,
  input  logic              req_ro,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LEN_W+2:0]  bus_bcount,
  output logic              bus_tag,
  output logic              bus_ns,
  output logic              bus_ro,
  input  logic              cpl_valid,
  input  logic              cpl_tag,
  input  logic              cpl_final
);
  logic  piece_valid;
  logic  piece_last;
  attr_t piece_attr;
  attr_t in_attr;
  logic  tag_avail;
  tag_t  tag_sel;
  logic  bus_fire;

  assign in_attr   = '{ns: req_ns, ro: req_ro};
  assign bus_valid = piece_valid && tag_avail;
  assign bus_fire  = bus_valid && bus_ready;
  assign bus_tag   = tag_sel;
  assign bus_ns    = piece_attr.ns;
  assign bus_ro    = piece_attr.ro;

  rdreq_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)) u_split (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_addr(req_addr), .in_len(req_len), .in_attr(in_attr),
    .piece_valid(piece_valid), .piece_take(bus_fire),
    .piece_addr(bus_addr), .piece_bcount(bus_bcount),
    .piece_attr(piece_attr), .piece_last(piece_last)
  );

  rdreq_tag_pool u_tags (
    .clk(clk), .rst_n(rst_n),
    .want(piece_valid), .take(bus_fire),
    .rel_valid(cpl_valid), .rel_tag(cpl_tag), .rel_final(cpl_final),
    .avail(tag_avail), .tag(tag_sel)
  );

  // R9: a waiting request keeps all its fields
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=>
      (bus_valid && $stable(bus_addr) && $stable(bus_bcount) &&
       $stable(bus_tag) && $stable(bus_ns) && $stable(bus_ro)));

  // R8: no new request is taken while pieces are pending
  assert_no_accept_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !(bus_fire && piece_last)) |=> !req_ready);
endmodule

// File: tb/sim_pcix_rdreq_gen.sv
module sim_pcix_rdreq_gen;
  localparam int ADDR_W = 64;
  localparam int LEN_W  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_ns = 0, req_ro = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_ready, bus_valid, bus_tag, bus_ns, bus_ro;
  logic bus_ready = 0;
  logic [ADDR_W-1:0] bus_addr;
  logic [LEN_W+2:0] bus_bcount;
  logic cpl_valid = 0, cpl_tag = 0, cpl_final = 0;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  pcix_rdreq_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(12)) u0 (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] a, input logic [9:0] len, input logic ns, input logic ro);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_len = len; req_ns = ns; req_ro = ro;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  // called at a falling edge; checks the offered piece and takes it
  task automatic take_piece(input string req, input logic [63:0] a, input int bc,
                            input logic tg, input logic ns, input logic ro);
    int n = 0;
    while (!bus_valid && n < 10) begin @(negedge clk); n++; end
    check({req, " valid"}, bus_valid, 1);
    check({req, " addr"}, bus_addr, a);
    check({req, " bcount"}, 64'(bus_bcount), 64'(bc));
    check({req, " tag"}, bus_tag, tg);
    check("R6 ns", bus_ns, ns);
    check("R7 ro", bus_ro, ro);
    bus_ready = 1;
    @(posedge clk);
    @(negedge clk);
    bus_ready = 0;
  endtask

  task automatic complete(input logic tg, input logic fin);
    @(negedge clk);
    cpl_valid = 1; cpl_tag = tg; cpl_final = fin;
    @(posedge clk);
    @(negedge clk);
    cpl_valid = 0; cpl_final = 0;
  endtask

  task automatic free_all;
    complete(0, 1);
    complete(1, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 bus_valid", bus_valid, 0);
    check("R10 req_ready", req_ready, 1);
  endtask

  task automatic t_single; // R1 R4 R6
    send(64'h1234_5678_0000_0100, 10'd16, 1, 0);
    take_piece("R1 single", 64'h1234_5678_0000_0100, 64, 0, 1, 0);
    check("R8 ready after last", req_ready, 1);
    free_all();
  endtask

  task automatic t_cross; // R2
    send(64'h0000_0000_0000_0FF0, 10'd8, 0, 0);
    take_piece("R2 first", 64'h0FF0, 16, 0, 0, 0);
    check("R8 ready low between pieces", req_ready, 0);
    take_piece("R2 second", 64'h1000, 16, 1, 0, 0);
    free_all();
  endtask

  task automatic t_exact; // R2 ends on boundary, no split
    send(64'h0F00, 10'd64, 0, 0);
    take_piece("R2 exact", 64'h0F00, 256, 0, 0, 0);
    check("R2 no second piece", bus_valid, 0);
    free_all();
  endtask

  task automatic t_maxlen; // R1 zero length
    send(64'h2000, 10'd0, 1, 1);
    take_piece("R1 len0 aligned", 64'h2000, 4096, 0, 1, 1);
    check("R1 len0 one piece", bus_valid, 0);
    free_all();
    send(64'h5004, 10'd0, 0, 1);
    take_piece("R1 len0 first", 64'h5004, 4092, 0, 0, 1);
    take_piece("R1 len0 second", 64'h6000, 4, 1, 0, 1);
    free_all();
  endtask

  task automatic t_4g; // R2 R7
    send(64'h0000_0000_FFFF_FFF8, 10'd4, 0, 1);
    take_piece("R2 4G first", 64'h0000_0000_FFFF_FFF8, 8, 0, 0, 1);
    take_piece("R2 4G second", 64'h0000_0001_0000_0000, 8, 1, 0, 1);
    free_all();
  endtask

  task automatic t_stall; // R3 R4 R5
    send(64'h100, 10'd1, 0, 0);
    take_piece("R4 first tag", 64'h100, 4, 0, 0, 0);
    send(64'h200, 10'd1, 0, 0);
    take_piece("R4 next tag", 64'h200, 4, 1, 0, 0);
    send(64'h300, 10'd1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      check("R3 stall no tags", bus_valid, 0);
      @(negedge clk);
    end
    complete(1, 0);
    for (int i = 0; i < 2; i++) begin
      check("R5 nonfinal keeps tag", bus_valid, 0);
      @(negedge clk);
    end
    complete(1, 1);
    check("R5 final frees tag", bus_valid, 1);
    take_piece("R3 reused tag", 64'h300, 4, 1, 0, 0);
    free_all();
  endtask

  task automatic t_hold; // R9
    send(64'h400, 10'd1, 0, 0);
    take_piece("R4 hold setup", 64'h400, 4, 0, 0, 0);
    send(64'h500, 10'd2, 1, 0);
    check("R4 tag1 while tag0 held", bus_tag, 1);
    complete(0, 1);
    @(negedge clk);
    check("R9 valid held", bus_valid, 1);
    check("R9 tag held", bus_tag, 1);
    check("R9 addr held", bus_addr, 64'h500);
    take_piece("R9 taken", 64'h500, 8, 1, 1, 0);
    free_all();
  endtask

  task automatic t_order; // R8
    send(64'h7FF8, 10'd4, 0, 0);
    check("R8 busy", req_ready, 0);
    fork
      send(64'h9000, 10'd2, 1, 1);
    join_none
    take_piece("R8 A first", 64'h7FF8, 8, 0, 0, 0);
    take_piece("R8 A second", 64'h8000, 8, 1, 0, 0);
    complete(0, 1);
    take_piece("R8 B after A", 64'h9000, 8, 0, 1, 1);
    wait fork;
    free_all();
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_single();
        t_cross();
        t_exact();
        t_maxlen();
        t_4g();
        t_stall();
        t_hold();
        t_order();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule